// File: doc/BRIEF.md
# Two-Layer Trigger Routing Fabric

This block carries single-bit trigger events from source peripherals to destination peripherals. It uses two cascaded selection layers. The first, reduction, layer is made of groups. Each group owns a slice of the source trigger lines and drives a few intermediate lines. The second, distribution, layer is also made of groups. Each of these picks among intermediate lines only and drives the destination trigger inputs. To route one source to one destination, software configures two outputs: one in a reduction group and one in a distribution group.

Every output of either layer has its own configuration word, written through a single-cycle write port. The word holds four fields:
- an input select;
- an invert flag, applied to the selected signal;
- a mode flag choosing level following or rising-edge pulse generation;
- a freeze flag. When the freeze flag is set and the chip-level debug halt is high, the output is forced low.

Each output is registered once, so a level change at a source reaches a destination two clocks later.

Top module: `trigRouteFabric`

## Requirements
- R1: While reset is asserted and after it is released, every configuration word is zero and every destination output is 0.
- R2: Select value 0, and any select value above the group's input count, means "no input": that output is 0 whatever its invert flag.
- R3: In level mode an output registers its conditioned input once. A source change appears at a destination after exactly two rising clock edges, one per layer.
- R4: When the invert flag is set, the selected signal is inverted before conditioning. Inversion in both layers cancels.
- R5: In edge mode, a rising edge of the conditioned input produces an output pulse exactly two clocks wide. An input held high afterwards produces no further pulse.
- R6: While debugHalt is 1 and an output's freeze flag is set, that output is 0 from the next clock. It resumes normal behaviour once debugHalt falls. Halt has no effect on outputs whose freeze flag is clear.
- R7: The write identifier wrAddr uses these fields:
  - bit 12 selects the layer (0 reduction, 1 distribution);
  - bits 11:8 hold the group number;
  - bit 7 must be 0;
  - bits 6:0 hold the output index within the group.

  A write with bit 7 set, a group number at or beyond the layer's group count, or an index at or beyond its outputs per group changes no configuration.
- R8: wrData is laid out as follows:
  - bits 3:0 hold the select;
  - bit 4 is invert;
  - bit 5 is edge mode (1 means edge);
  - bit 6 is freeze.

  Select value s in 1..8 picks group input s-1. Reduction group g input k is source line g*8+k. Distribution group d input k is intermediate line (d*8+k) mod 16. Intermediate line g*4+i is output i of reduction group g.
- R9: A configuration write is stored at the clock edge on which wrEn is sampled high. The datapath uses the new value from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTrig | input | 32 | Source peripheral trigger lines |
| debugHalt | input | 1 | Debug halt indication used by the freeze flags |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 13 | Output identifier: layer, group, index |
| wrData | input | 7 | Configuration word: select, invert, edge, freeze |
| dstTrig | output | 16 | Routed destination triggers, distribution group d output j at bit d*4+j |

## Verification
The bench targets the places where a plausible design goes wrong.

An invert flag on an unselected output must not turn the "no input" level into a constant high. An out-of-range select must not wrap onto a real input. Write decoding that truncates the group or index field would alias an out-of-range write onto a live output and silence it. A missing or extra register stage would shift the two-clock latency. In edge mode, a design that counts a held-high input as repeated edges would emit extra pulses, while one that stretches the pulse wrongly would give a width other than two. Freeze must silence only flagged outputs during halt, and must let them recover once the halt ends.

// File: rtl/trigRoutePkg.sv
`timescale 1ns/1ps
package trigRoutePkg;
  // Output identifier width: layer bit, 4-bit group, spare bit, 7-bit index
  localparam int ID_W = 13;

  typedef struct packed {
    logic freeze;
    logic edgeMode;
    logic invert;
  } outFlags_t;
endpackage

// File: rtl/trigRouteCfg.sv
`timescale 1ns/1ps
module trigRouteCfg
  import trigRoutePkg::*;
#(
  parameter int RED_GROUPS = 4,
  parameter int RED_OUTS   = 4,
  parameter int DST_GROUPS = 4,
  parameter int DST_OUTS   = 4,
  parameter int SEL_W      = 4,
  localparam int RED_N = RED_GROUPS * RED_OUTS,
  localparam int DST_N = DST_GROUPS * DST_OUTS,
  localparam int CFG_W = SEL_W + 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ID_W-1:0]               wrAddr,
  input  logic [CFG_W-1:0]              wrData,
  output logic [RED_N-1:0][SEL_W-1:0]   redSel,
  output outFlags_t [RED_N-1:0]         redFlags,
  output logic [DST_N-1:0][SEL_W-1:0]   dstSel,
  output outFlags_t [DST_N-1:0]         dstFlags
);
  logic       layerBit;
  logic       spareOk;
  logic [3:0] grpField;
  logic [6:0] idxField;
  logic       redHit, dstHit;
  int         redIdx, dstIdx;

  assign layerBit = wrAddr[12];
  assign grpField = wrAddr[11:8];
  assign spareOk  = !wrAddr[7];
  assign idxField = wrAddr[6:0];

  always_comb begin
    redIdx = int'(grpField) * RED_OUTS + int'(idxField);
    dstIdx = int'(grpField) * DST_OUTS + int'(idxField);
    redHit = wrEn && spareOk && !layerBit &&
             (int'(grpField) < RED_GROUPS) && (int'(idxField) < RED_OUTS);
    dstHit = wrEn && spareOk && layerBit &&
             (int'(grpField) < DST_GROUPS) && (int'(idxField) < DST_OUTS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redSel   <= '0;
      redFlags <= '0;
      dstSel   <= '0;
      dstFlags <= '0;
    end else begin
      for (int o = 0; o < RED_N; o++) begin
        if (redHit && redIdx == o) begin
          redSel[o]   <= wrData[SEL_W-1:0];
          redFlags[o] <= outFlags_t'(wrData[SEL_W+2:SEL_W]);
        end
      end
      for (int o = 0; o < DST_N; o++) begin
        if (dstHit && dstIdx == o) begin
          dstSel[o]   <= wrData[SEL_W-1:0];
          dstFlags[o] <= outFlags_t'(wrData[SEL_W+2:SEL_W]);
        end
      end
    end
  end

  // R7
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !redHit && !dstHit) |=>
      ($stable(redSel) && $stable(redFlags) && $stable(dstSel) && $stable(dstFlags)));

  // R9
  red_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    redHit |=> (redSel[$past(redIdx)] == $past(wrData[SEL_W-1:0])));

  // R9
  dst_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    dstHit |=> (dstSel[$past(dstIdx)] == $past(wrData[SEL_W-1:0])));
endmodule

// File: rtl/trigRouteLayer.sv
`timescale 1ns/1ps
module trigRouteLayer
  import trigRoutePkg::*;
#(
  parameter int GROUPS       = 4,
  parameter int IN_PER_GRP   = 8,
  parameter int OUTS_PER_GRP = 4,
  parameter int NUM_IN       = 32,
  parameter int SEL_W        = 4,
  localparam int N = GROUPS * OUTS_PER_GRP
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         inVec,
  input  logic                      debugHalt,
  input  logic [N-1:0][SEL_W-1:0]   sel,
  input  outFlags_t [N-1:0]         flags,
  output logic [N-1:0]              outVec
);
  logic [GROUPS-1:0][IN_PER_GRP-1:0] grpIn;
  logic [N-1:0] condV;
  logic [N-1:0] prevQ, holdQ, outQ;

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    for (genvar k = 0; k < IN_PER_GRP; k++) begin : gIn
      assign grpIn[g][k] = inVec[(g * IN_PER_GRP + k) % NUM_IN];
    end
  end

  for (genvar o = 0; o < N; o++) begin : gOut
    localparam int G = o / OUTS_PER_GRP;
    logic pick, hit;
    always_comb begin
      pick = 1'b0;
      hit  = 1'b0;
      for (int k = 0; k < IN_PER_GRP; k++) begin
        if (sel[o] == SEL_W'(k + 1)) begin
          pick = grpIn[G][k];
          hit  = 1'b1;
        end
      end
    end
    assign condV[o] = hit & (pick ^ flags[o].invert);

    // R6
    freeze_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (debugHalt && flags[o].freeze) |=> !outQ[o]);

    // R2
    no_input_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sel[o] == '0 && !holdQ[o]) |=> !outQ[o]);

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!flags[o].edgeMode && !(debugHalt && flags[o].freeze) && sel[o] == SEL_W'(1))
        |=> (outQ[o] == $past(grpIn[G][0] ^ flags[o].invert)));

    // R5
    pulse_two_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(outQ[o]) && flags[o].edgeMode && !(debugHalt && flags[o].freeze))
        |=> outQ[o]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      holdQ <= '0;
      outQ  <= '0;
    end else begin
      prevQ <= condV;
      for (int o = 0; o < N; o++) begin
        if (debugHalt && flags[o].freeze) begin
          outQ[o]  <= 1'b0;
          holdQ[o] <= 1'b0;
        end else if (!flags[o].edgeMode) begin
          outQ[o]  <= condV[o];
          holdQ[o] <= 1'b0;
        end else if (condV[o] && !prevQ[o]) begin
          outQ[o]  <= 1'b1;
          holdQ[o] <= 1'b1;
        end else begin
          outQ[o]  <= holdQ[o];
          holdQ[o] <= 1'b0;
        end
      end
    end
  end

  assign outVec = outQ;
endmodule

// File: rtl/trigRouteFabric.sv
`timescale 1ns/1ps
module trigRouteFabric
  import trigRoutePkg::*;
#(
  parameter int RED_GROUPS = 4,
  parameter int RED_INS    = 8,
  parameter int RED_OUTS   = 4,
  parameter int DST_GROUPS = 4,
  parameter int DST_INS    = 8,
  parameter int DST_OUTS   = 4,
  localparam int NUM_SRC = RED_GROUPS * RED_INS,
  localparam int NUM_MID = RED_GROUPS * RED_OUTS,
  localparam int NUM_DST = DST_GROUPS * DST_OUTS,
  localparam int MAX_INS = (RED_INS > DST_INS) ? RED_INS : DST_INS,
  localparam int SEL_W   = $clog2(MAX_INS + 1),
  localparam int CFG_W   = SEL_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTrig,
  input  logic               debugHalt,
  input  logic               wrEn,
  input  logic [ID_W-1:0]    wrAddr,
  input  logic [CFG_W-1:0]   wrData,
  output logic [NUM_DST-1:0] dstTrig
);
  logic [NUM_MID-1:0][SEL_W-1:0] redSel;
  outFlags_t [NUM_MID-1:0]       redFlags;
  logic [NUM_DST-1:0][SEL_W-1:0] dstSel;
  outFlags_t [NUM_DST-1:0]       dstFlags;
  logic [NUM_MID-1:0]            midTrig;

  trigRouteCfg #(
    .RED_GROUPS(RED_GROUPS), .RED_OUTS(RED_OUTS),
    .DST_GROUPS(DST_GROUPS), .DST_OUTS(DST_OUTS), .SEL_W(SEL_W)
  ) uCfg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .redSel(redSel), .redFlags(redFlags), .dstSel(dstSel), .dstFlags(dstFlags)
  );

  trigRouteLayer #(
    .GROUPS(RED_GROUPS), .IN_PER_GRP(RED_INS), .OUTS_PER_GRP(RED_OUTS),
    .NUM_IN(NUM_SRC), .SEL_W(SEL_W)
  ) uRed (
    .clk(clk), .rstN(rstN), .inVec(srcTrig), .debugHalt(debugHalt),
    .sel(redSel), .flags(redFlags), .outVec(midTrig)
  );

  trigRouteLayer #(
    .GROUPS(DST_GROUPS), .IN_PER_GRP(DST_INS), .OUTS_PER_GRP(DST_OUTS),
    .NUM_IN(NUM_MID), .SEL_W(SEL_W)
  ) uDst (
    .clk(clk), .rstN(rstN), .inVec(midTrig), .debugHalt(debugHalt),
    .sel(dstSel), .flags(dstFlags), .outVec(dstTrig)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (dstTrig == '0));
endmodule

// File: tb/sim_trigRouteFabric.sv
`timescale 1ns/1ps
module sim_trigRouteFabric;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcTrig = '0;
  logic        debugHalt = 1'b0;
  logic        wrEn = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [6:0]  wrData = '0;
  logic [15:0] dstTrig;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  trigRouteFabric u0 (
    .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .debugHalt(debugHalt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .dstTrig(dstTrig)
  );

  typedef struct packed {
    int src; int redOut; int dGrp; int dIdx; bit invR; bit invD;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{0,  0, 0, 0, 1'b0, 1'b0},
    '{13, 2, 2, 3, 1'b1, 1'b0},
    '{31, 3, 3, 0, 1'b0, 1'b1},
    '{20, 1, 1, 2, 1'b1, 1'b1},
    '{7,  3, 0, 1, 1'b0, 1'b1},
    '{26, 0, 3, 3, 1'b1, 1'b0}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #4;
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] cfgWord(int sel, bit inv, bit edg, bit frz);
    return {frz, edg, inv, 4'(sel)};
  endfunction

  task automatic cfgWrite(bit layer, int grp, int idx, logic [6:0] data, bit spare = 1'b0);
    wrAddr = {layer, 4'(grp), spare, 7'(idx)};
    wrData = data;
    wrEn   = 1'b1;
    step();
    wrEn   = 1'b0;
  endtask

  // Distribution select (1-based) that reaches intermediate line m from group d
  function automatic int dstSelFor(int m, int d);
    return ((((m - d * 8) % 16) + 16) % 16) + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    srcTrig = '1;
    step(3);
    chk("R1 in reset", |dstTrig, 1'b0);
    rstN = 1'b1;
    step(3);
    chk("R1 after reset, unconfigured", |dstTrig, 1'b0);

    // R2: no-input select ignores invert, including out-of-range select
    cfgWrite(1'b1, 0, 0, cfgWord(0, 1'b1, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 1, cfgWord(9, 1'b1, 1'b0, 1'b0));
    cfgWrite(1'b0, 0, 2, cfgWord(15, 1'b1, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 2, cfgWord(3, 1'b0, 1'b0, 1'b0));
    step(3);
    chk("R2 select 0 with invert", dstTrig[0], 1'b0);
    chk("R2 select 9 with invert", dstTrig[1], 1'b0);
    chk("R2 reduction select 15 with invert", dstTrig[2], 1'b0);
    cfgWrite(1'b1, 0, 0, cfgWord(0, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 1, cfgWord(0, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 2, cfgWord(0, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b0, 0, 2, cfgWord(0, 1'b0, 1'b0, 1'b0));

    // R3 R4 R8: table of level routes
    foreach (VECS[v]) begin
      automatic int g   = VECS[v].src / 8;
      automatic int k   = VECS[v].src % 8;
      automatic int m   = g * 4 + VECS[v].redOut;
      automatic int bit_ = VECS[v].dGrp * 4 + VECS[v].dIdx;
      automatic logic base = VECS[v].invR ^ VECS[v].invD;
      cfgWrite(1'b0, g, VECS[v].redOut, cfgWord(k + 1, VECS[v].invR, 1'b0, 1'b0));
      cfgWrite(1'b1, VECS[v].dGrp, VECS[v].dIdx,
               cfgWord(dstSelFor(m, VECS[v].dGrp), VECS[v].invD, 1'b0, 1'b0));
      srcTrig = '0;
      step(3);
      chk("R4 R8 idle level", dstTrig[bit_], base);
      srcTrig[VECS[v].src] = 1'b1;
      step();
      chk("R3 one edge not yet through", dstTrig[bit_], base);
      step();
      chk("R3 R8 through after two edges", dstTrig[bit_], ~base);
      srcTrig = ~(32'd1 << VECS[v].src);
      step(2);
      chk("R8 other sources do not reach", dstTrig[bit_], base);
    end

    // Clean slate for the directed tests
    for (int o = 0; o < 16; o++) cfgWrite(1'b1, o / 4, o % 4, 7'd0);
    for (int o = 0; o < 16; o++) cfgWrite(1'b0, o / 4, o % 4, 7'd0);
    srcTrig = '0;

    // R5: distribution edge mode, reduction level
    cfgWrite(1'b0, 0, 0, cfgWord(1, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 0, cfgWord(1, 1'b0, 1'b1, 1'b0));
    step(3);
    srcTrig[0] = 1'b1;
    step();
    chk("R5 edge before reaching second layer", dstTrig[0], 1'b0);
    step();
    chk("R5 pulse first cycle", dstTrig[0], 1'b1);
    step();
    chk("R5 pulse second cycle", dstTrig[0], 1'b1);
    step();
    chk("R5 pulse ends after two", dstTrig[0], 1'b0);
    step(3);
    chk("R5 held input no repeat", dstTrig[0], 1'b0);

    // R5: reduction edge mode, distribution level
    srcTrig = '0;
    cfgWrite(1'b0, 0, 0, cfgWord(1, 1'b0, 1'b1, 1'b0));
    cfgWrite(1'b1, 0, 0, cfgWord(1, 1'b0, 1'b0, 1'b0));
    step(3);
    srcTrig[0] = 1'b1;
    step(2);
    chk("R5 reduction pulse seen cycle 1", dstTrig[0], 1'b1);
    step();
    chk("R5 reduction pulse seen cycle 2", dstTrig[0], 1'b1);
    step();
    chk("R5 reduction pulse over", dstTrig[0], 1'b0);

    // R6: freeze
    cfgWrite(1'b0, 0, 0, cfgWord(1, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 1, cfgWord(1, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 0, 0, cfgWord(1, 1'b0, 1'b0, 1'b1));
    step(2);
    chk("R6 freeze flag without halt", dstTrig[0], 1'b1);
    debugHalt = 1'b1;
    step();
    chk("R6 frozen output low", dstTrig[0], 1'b0);
    chk("R6 unflagged output unaffected", dstTrig[1], 1'b1);
    debugHalt = 1'b0;
    step();
    chk("R6 resumes after halt", dstTrig[0], 1'b1);

    // R9: write takes effect on the following edge
    cfgWrite(1'b1, 0, 1, cfgWord(0, 1'b0, 1'b0, 1'b0));
    chk("R9 old config still used", dstTrig[1], 1'b1);
    step();
    chk("R9 new config applied", dstTrig[1], 1'b0);

    // R7: out-of-range writes ignored (would alias group 1 index 0)
    cfgWrite(1'b0, 2, 0, cfgWord(1, 1'b0, 1'b0, 1'b0));
    cfgWrite(1'b1, 1, 0, cfgWord(1, 1'b0, 1'b0, 1'b0));
    srcTrig[16] = 1'b1;
    step(2);
    chk("R7 R8 route via group 2 to group 1", dstTrig[4], 1'b1);
    cfgWrite(1'b1, 5, 0, 7'd0);
    step(2);
    chk("R7 group beyond range ignored", dstTrig[4], 1'b1);
    cfgWrite(1'b1, 1, 4, 7'd0);
    step(2);
    chk("R7 index beyond range ignored", dstTrig[4], 1'b1);
    cfgWrite(1'b1, 1, 0, 7'd0, 1'b1);
    step(2);
    chk("R7 spare bit set ignored", dstTrig[4], 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule